// File: doc/BRIEF.md
# Autoregressive Time-Series Predictor

This block runs inference for a small nonlinear autoregressive neural network in fixed point and predicts the next sample of a time series. A delay line holds the sixteen most recent samples. Each of five hidden neurons starts from its bias and adds the product of every tap with its own weight. The saturated sum goes through a tanh lookup table. A linear output neuron then sums the five activations, each times its weight, on top of an output bias. All weights and biases come from a parameter ROM inside the block. One multiplier does all of the multiply-accumulate work, one operand pair per clock.

Operation starts with seeding. The block raises `in_ready` and accepts sixteen samples through the `in_valid`/`in_ready` handshake. It then computes on its own. Each prediction is offered on `out_valid`/`out_data`. When the consumer takes the prediction, the block pushes it into the delay line as the newest tap and begins the next step, so the series continues from its own output. Back-pressure rules are as follows. A prediction stays on the port, unchanged, until `out_ready` is sampled high. No new computation starts until the prediction is taken. Samples are taken only while `in_ready` is high, which is during seeding only. `start` is a plain control pin: it abandons whatever is in progress and returns the block to seeding.

Top module: `nar_engine`

## Requirements
- R1: During reset and right after it, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is high only while seeding. A sample is accepted on a clock edge where `in_valid` and `in_ready` are both 1. The most recently accepted sample becomes tap 0 and older ones move up by one. The sixteenth accepted sample ends seeding.
- R3: `out_valid` rises exactly LAT = NHID*(NTAPS+2)+NHID+1 clock edges after either the edge that accepted the last seed sample or the edge of an output handshake. With the defaults, LAT is 96.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R5: On an output handshake, `out_valid` drops on that edge. The prediction becomes tap 0, the oldest tap is discarded, and the next prediction uses the updated line.
- R6: Hidden neuron j starts its sum at its bias. For each tap t it adds floor(tap[t]·w[j][t] / 2^Q), and that term is saturated to N-bit signed before it is added. The final sum is saturated to N-bit signed and becomes the pre-activation.
- R7: Activation rule. A pre-activation p ≥ 4.0 (4·2^Q) gives +1.0 (2^Q), and p < −4.0 gives −1.0. Otherwise the index is i = (p + 4·2^Q) >> (Q−4), and the output is floor(2^Q·tanh(x) + 0.5), where x = (−4·2^Q + i·2^(Q−4) + 2^(Q−5)) / 2^Q.
- R8: The output neuron is linear. It starts from the output bias and adds each activation times its weight, using the same per-term rule as R6. The sum, saturated to N-bit signed, is `out_data`.
- R9: ROM word a holds (((53a+17) mod 113) − 56)·2^(Q−6). The layout is: hidden biases at 0..NHID−1; the weight of neuron j for tap t at NHID + j·NTAPS + t; the output bias next; then the output weights in hidden-neuron order.
- R10: With `start` high on an edge, the block returns to seeding with an empty seed count. `out_valid` is 0 and `in_ready` is 1 after that edge, and `start` takes priority over every other input.
- R11: `in_valid` and `in_data` have no effect while `in_ready` is 0. Predictions and timing match those of a run with `in_valid` held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Abandon current work and return to seeding |
| in_valid | input | 1 | Seed sample offered |
| in_ready | output | 1 | Block is seeding and accepts samples |
| in_data | input | N | Seed sample, signed Q-fraction fixed point |
| out_valid | output | 1 | Prediction available |
| out_ready | input | 1 | Consumer takes the prediction |
| out_data | output | N | Predicted sample, signed fixed point |

## Verification
The hardest situations to reach from the ports are saturation of the hidden sums and a pre-activation beyond the ±4.0 table edges, because small seed values keep every neuron in the table's middle. The stimulus therefore reseeds with samples near both ends of the N-bit range and with alternating signs, which drives sums into saturation and activations onto ±1.0. `start` is pulsed in three places: part-way through a computation, while a prediction is being held back, and during a partial seed. A behavioural model follows seeding, countdown and feedback on every clock, and the bench compares the handshake signals and data with it.

// File: rtl/nar_pkg.sv
package nar_pkg;

  typedef enum logic [2:0] {
    ST_SEED,
    ST_HID,
    ST_ACT,
    ST_OUT,
    ST_HOLD
  } nar_state_e;

  // Parameter word for ROM address a, scaled to q fractional bits.
  function automatic int rom_word(input int a, input int q);
    int raw;
    raw = ((a * 53 + 17) % 113) - 56;
    return raw * (1 << (q - 6));
  endfunction

endpackage

// File: rtl/nar_rom.sv
module nar_rom #(
  parameter int N     = 16,
  parameter int Q     = 8,
  parameter int DEPTH = 91,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0]       addr,
  output logic signed [N-1:0] data
);
  logic signed [N-1:0] mem [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign mem[a] = N'(nar_pkg::rom_word(a, Q));
  end

  assign data = mem[addr];
endmodule

// File: rtl/nar_mac.sv
module nar_mac #(
  parameter int N     = 16,
  parameter int Q     = 8,
  parameter int ACC_W = 22
) (
  input  logic signed [N-1:0]     op_a,
  input  logic signed [N-1:0]     op_b,
  input  logic signed [ACC_W-1:0] acc_in,
  output logic signed [ACC_W-1:0] acc_out
);
  localparam logic signed [2*N-1:0] HI = (2*N)'((1 << (N - 1)) - 1);
  localparam logic signed [2*N-1:0] LO = -HI - 1;

  logic signed [2*N-1:0] prod;
  logic signed [2*N-1:0] scaled;
  logic signed [N-1:0]   term;

  always_comb begin
    prod   = op_a * op_b;
    scaled = prod >>> Q;
    if (scaled > HI)      term = HI[N-1:0];
    else if (scaled < LO) term = LO[N-1:0];
    else                  term = scaled[N-1:0];
    acc_out = acc_in + ACC_W'(term);
  end
endmodule

// File: rtl/nar_tanh_lut.sv
module nar_tanh_lut #(
  parameter int N = 16,
  parameter int Q = 8
) (
  input  logic signed [N-1:0] pre,
  output logic signed [N-1:0] act
);
  localparam int ONE  = 1 << Q;
  localparam int LIM  = 4 * ONE;
  localparam int SH   = Q - 4;
  localparam int STEP = 1 << SH;
  localparam int ENT  = (2 * LIM) / STEP;
  localparam int IW   = $clog2(ENT);

  function automatic int tanh_entry(input int i);
    real x;
    x = real'(-LIM + i * STEP + STEP / 2) / real'(ONE);
    return $rtoi($floor($tanh(x) * real'(ONE) + 0.5));
  endfunction

  logic signed [N-1:0] tab [ENT];
  for (genvar i = 0; i < ENT; i++) begin : g_tab
    assign tab[i] = N'(tanh_entry(i));
  end

  logic [IW-1:0] idx;

  always_comb begin
    idx = IW'((int'(pre) + LIM) >>> SH);
    if (int'(pre) >= LIM)      act = N'(ONE);
    else if (int'(pre) < -LIM) act = N'(-ONE);
    else                       act = tab[idx];
  end
endmodule

// File: rtl/nar_engine.sv
module nar_engine #(
  parameter int N     = 16,
  parameter int Q     = 8,
  parameter int NTAPS = 16,
  parameter int NHID  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [N-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [N-1:0] out_data
);
  import nar_pkg::*;

  localparam int L0B   = 0;
  localparam int L0W   = NHID;
  localparam int L1B   = NHID + NHID * NTAPS;
  localparam int L1W   = L1B + 1;
  localparam int DEPTH = L1W + NHID;
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(NTAPS + 1);
  localparam int TAP_W = $clog2(NTAPS);
  localparam int HID_W = (NHID > 1) ? $clog2(NHID) : 1;
  localparam int ACC_W = N + $clog2(NTAPS + 2) + 1;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (N - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

  nar_state_e state;
  logic signed [N-1:0]     taps [NTAPS];
  logic signed [N-1:0]     hid  [NHID];
  logic signed [ACC_W-1:0] acc;
  logic [CNT_W-1:0]        cnt;
  logic [CNT_W-1:0]        cm1;
  logic [HID_W-1:0]        nidx;
  logic [CNT_W-1:0]        seed_cnt;

  logic [AW-1:0]           rom_addr;
  logic signed [N-1:0]     rom_data;
  logic signed [N-1:0]     mac_a;
  logic signed [ACC_W-1:0] mac_out;
  logic signed [N-1:0]     pre_act;
  logic signed [N-1:0]     act;

  function automatic logic signed [N-1:0] sat_n(input logic signed [ACC_W-1:0] v);
    if (v > SAT_HI)      return SAT_HI[N-1:0];
    else if (v < SAT_LO) return SAT_LO[N-1:0];
    else                 return v[N-1:0];
  endfunction

  assign in_ready = (state == ST_SEED);
  assign cm1      = (cnt == '0) ? '0 : cnt - 1'b1;
  assign pre_act  = sat_n(acc);

  // Operand and ROM address selection for the single MAC.
  always_comb begin
    if (state == ST_OUT) begin
      mac_a    = hid[cm1[HID_W-1:0]];
      rom_addr = (cnt == '0) ? AW'(L1B) : AW'(L1W + int'(cm1));
    end else begin
      mac_a    = taps[cm1[TAP_W-1:0]];
      rom_addr = (cnt == '0) ? AW'(L0B + int'(nidx))
                             : AW'(L0W + int'(nidx) * NTAPS + int'(cm1));
    end
  end

  nar_rom #(.N(N), .Q(Q), .DEPTH(DEPTH)) u_rom (
    .addr (rom_addr),
    .data (rom_data)
  );

  nar_mac #(.N(N), .Q(Q), .ACC_W(ACC_W)) u_mac (
    .op_a    (mac_a),
    .op_b    (rom_data),
    .acc_in  (acc),
    .acc_out (mac_out)
  );

  nar_tanh_lut #(.N(N), .Q(Q)) u_lut (
    .pre (pre_act),
    .act (act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_SEED;
      acc       <= '0;
      cnt       <= '0;
      nidx      <= '0;
      seed_cnt  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int i = 0; i < NTAPS; i++) taps[i] <= '0;
      for (int j = 0; j < NHID; j++)  hid[j]  <= '0;
    end else if (start) begin
      state     <= ST_SEED;
      seed_cnt  <= '0;
      out_valid <= 1'b0;
    end else begin
      unique case (state)
        ST_SEED: begin
          if (in_valid) begin
            for (int i = NTAPS - 1; i > 0; i--) taps[i] <= taps[i-1];
            taps[0] <= in_data;
            if (seed_cnt == CNT_W'(NTAPS - 1)) begin
              seed_cnt <= '0;
              cnt      <= '0;
              nidx     <= '0;
              state    <= ST_HID;
            end else begin
              seed_cnt <= seed_cnt + 1'b1;
            end
          end
        end
        ST_HID: begin
          acc <= (cnt == '0) ? ACC_W'(rom_data) : mac_out;
          if (cnt == CNT_W'(NTAPS)) state <= ST_ACT;
          else                      cnt   <= cnt + 1'b1;
        end
        ST_ACT: begin
          hid[nidx] <= act;
          cnt       <= '0;
          if (nidx == HID_W'(NHID - 1)) begin
            nidx  <= '0;
            state <= ST_OUT;
          end else begin
            nidx  <= nidx + 1'b1;
            state <= ST_HID;
          end
        end
        ST_OUT: begin
          acc <= (cnt == '0) ? ACC_W'(rom_data) : mac_out;
          if (cnt == CNT_W'(NHID)) begin
            out_data  <= sat_n(mac_out);
            out_valid <= 1'b1;
            state     <= ST_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (out_ready) begin
            for (int i = NTAPS - 1; i > 0; i--) taps[i] <= taps[i-1];
            taps[0]   <= out_data;
            out_valid <= 1'b0;
            cnt       <= '0;
            nidx      <= '0;
            state     <= ST_HID;
          end
        end
        default: state <= ST_SEED;
      endcase
    end
  end
endmodule

// File: rtl/nar_engine_chk.sv
module nar_engine_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] out_data
);
  // R4: a held prediction neither disappears nor changes
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

  // R5: taken prediction is withdrawn on the same edge
  a_r5_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  // R2: seeding and a pending prediction never overlap
  a_r2_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  // R10: start always lands back in seeding
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (in_ready && !out_valid));

  // R1: reset state
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (!out_valid);
    end
  end
endmodule

bind nar_engine nar_engine_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/nar_engine_tb.sv
`timescale 1ns/1ps
module nar_engine_tb;
  localparam int NB  = 16;
  localparam int QB  = 8;
  localparam int NT  = 16;
  localparam int NH  = 5;
  localparam int LAT = NH * (NT + 2) + NH + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [NB-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [NB-1:0] out_data;

  always #5 clk = ~clk;

  nar_engine u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_taps [NT];
  int m_seed = 0;
  int m_cd = 0;
  bit m_valid = 0;
  int m_data = 0;
  int m_taken = 0;

  function automatic int rom(input int a);
    return (((a * 53 + 17) % 113) - 56) * (1 << (QB - 6));
  endfunction

  function automatic int satn(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int term(input int a, input int b);
    longint p;
    p = longint'(a) * longint'(b);
    p = p >>> QB;
    return satn(p);
  endfunction

  function automatic int tanh_ref(input int p);
    int i;
    real x;
    if (p >= 4 * (1 << QB)) return 1 << QB;
    if (p < -4 * (1 << QB)) return -(1 << QB);
    i = (p + 4 * (1 << QB)) >>> (QB - 4);
    x = real'(-4 * (1 << QB) + i * (1 << (QB - 4)) + (1 << (QB - 5))) / real'(1 << QB);
    return $rtoi($floor($tanh(x) * real'(1 << QB) + 0.5));
  endfunction

  // R6 R7 R8 R9: arithmetic of both layers over the ROM layout
  function automatic int predict();
    int h [NH];
    longint acc;
    for (int j = 0; j < NH; j++) begin
      acc = rom(j);
      for (int t = 0; t < NT; t++) acc += term(m_taps[t], rom(NH + j * NT + t));
      h[j] = tanh_ref(satn(acc));
    end
    acc = rom(NH + NH * NT);
    for (int j = 0; j < NH; j++) acc += term(h[j], rom(NH + NH * NT + 1 + j));
    return satn(acc);
  endfunction

  function automatic void push(input int v);
    for (int i = NT - 1; i > 0; i--) m_taps[i] = m_taps[i-1];
    m_taps[0] = v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_seed = 0; m_cd = 0; m_valid = 0;
    end else if (start) begin
      m_seed = 0; m_cd = 0; m_valid = 0;
    end else if (m_seed < NT) begin
      if (in_valid) begin
        push(int'(in_data));
        m_seed++;
        if (m_seed == NT) m_cd = LAT;
      end
    end else if (m_cd > 0) begin
      m_cd--;
      if (m_cd == 0) begin
        m_valid = 1;
        m_data = predict();
      end
    end else if (m_valid && out_ready) begin
      push(m_data);            // R5: feedback into tap 0
      m_valid = 0;
      m_cd = LAT;
      m_taken++;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(in_ready == (m_seed < NT), "R2/R10/R11 in_ready", int'(in_ready), int'(m_seed < NT));
      check(out_valid == m_valid, "R3/R4/R5/R10 out_valid", int'(out_valid), int'(m_valid));
      if (m_valid && out_valid)
        check(int'(out_data) == m_data, "R5/R6/R7/R8/R9 out_data", int'(out_data), m_data);
    end
  end

  // ---------------- stimulus ----------------
  task automatic seed(input int kind, input int count);
    int n = 0;
    while (n < count) begin
      @(negedge clk);
      in_valid = ($urandom % 4) != 0;
      case (kind)
        0: in_data = NB'(n * 40 - 300);
        1: in_data = NB'(30000 + n * 150);
        2: in_data = (n % 2) ? NB'(-32768) : NB'(32767 - n);
        default: in_data = NB'(int'($urandom % 4000) - 2000);
      endcase
      if (in_valid) n++;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  // R11: junk on the input side while computing
  task automatic run(input int preds, input bit stall);
    int target = m_taken + preds;
    while (m_taken < target && !done) begin
      @(negedge clk);
      out_ready = stall ? (($urandom % 3) == 0) : 1'b1;
      in_valid = $urandom % 2;
      in_data = NB'($urandom);
    end
    @(negedge clk);
    out_ready = 0;
    in_valid = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    for (int i = 0; i < NT; i++) m_taps[i] = 0;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset", int'({in_ready, out_valid}), 2);

    seed(0, NT);
    run(6, 0);
    run(5, 1);

    // R10: abort mid-computation
    repeat (30) @(negedge clk);
    pulse_start();
    seed(1, NT);
    run(3, 0);

    // R10: start while a prediction is held back
    while (!out_valid && !done) @(negedge clk);
    repeat (3) @(negedge clk);
    pulse_start();
    seed(2, NT);
    run(3, 1);

    // R10: start during a partial seed
    pulse_start();
    seed(3, 7);
    pulse_start();
    seed(3, NT);
    run(4, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule